// File: doc/BRIEF.md
# Byte-Sliced Register File

A storage block of sixteen 32-bit words for a datapath that processes one 8-bit slice of a word per cycle. A single 2-bit slice select is shared by every port. It picks which 8-bit lane of the addressed words is read and which lane is written. The block has two read ports and one write port. Each read port returns the selected lane of its own word with no clock latency. The write port updates only the selected lane of one word, on the rising clock edge.

Word 0 is a constant zero. Reads of it always return zero, from power-on, and writes to it are dropped. An active-low reset is sampled on the clock edge and clears every word. It wins over a write in the same cycle. A debug output shows the whole array so that a bench can compare it with a model. Reads never forward the data being written in the same cycle.

Top module: `slreg_file`

## Requirements
- R1: The slice select value k (0 to 3) maps to bits [(k+1)*8-1 : k*8] of a word, for reads and writes alike.
- R2: Each read output follows its read address and the slice select combinationally, with zero cycles of latency.
- R3: Read port 0 and read port 1 use independent addresses and may read different words in the same cycle.
- R4: When rst_ni is sampled low at a rising edge, every word is zero after that edge, even if a write is requested in the same cycle.
- R5: No storage changes at an edge where wr_en_i is low.
- R6: A write places wr_data_i into the selected slice of the addressed word only. The other three slices and all other words keep their values.
- R7: A write to address 0 is discarded, and word 0 stays zero.
- R8: A read of address 0 returns zero at all times, including before the first reset.
- R9: A read of the word being written in the same cycle returns the value held before that cycle's rising edge.
- R10: dbg_words_o presents word n at index n, with bit b of the word at bit b of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes and reset act on its rising edge |
| rst_ni | input | 1 | Synchronous active-low clear of all words |
| slice_sel_i | input | 2 | Shared slice select for all ports |
| rd_addr_i | input | 2x4 | Word address for each read port |
| rd_data_o | output | 2x8 | Selected slice of each read port's word |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Word address of the write |
| wr_data_i | input | 8 | Slice data to write |
| dbg_words_o | output | 16x32 | Whole storage array, word n at index n |

## Verification
The bench writes two lanes of the same word and then reads each lane back. A design that clobbered neighbouring lanes, or misplaced the lane offset, returns wrong bytes at those reads. It reads a word while that word is being written. A design with forwarding would show the new byte one cycle early. It also writes to address 0, holds the write enable low with live data, and asserts reset together with a write. These catch designs that store into word 0, ignore the enable, or let a write survive reset. A check on address 0 before any reset catches a zero word that depends on reset.

// File: rtl/slreg_pkg.sv
package slreg_pkg;
  localparam int unsigned SLREG_WORD_W  = 32;
  localparam int unsigned SLREG_SLICE_W = 8;
  localparam int unsigned SLREG_ADDR_W  = 4;
  localparam int unsigned SLREG_NUM_RD  = 2;
endpackage

// File: rtl/slreg_wdec.sv
// Turns the write request into one enable per (word, slice); word 0 has none.
module slreg_wdec #(
  parameter int unsigned NUM_WORDS  = 16,
  parameter int unsigned NUM_SLICES = 4,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned SEL_W      = 2
) (
  input  logic                                   wr_en_i,
  input  logic [ADDR_W-1:0]                      wr_addr_i,
  input  logic [SEL_W-1:0]                       slice_sel_i,
  output logic [NUM_WORDS-1:1][NUM_SLICES-1:0]   slice_we_o
);
  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      assign slice_we_o[w][s] = wr_en_i
                              && (wr_addr_i == ADDR_W'(w))
                              && (slice_sel_i == SEL_W'(s));
    end
  end
endmodule

// File: rtl/slreg_store.sv
module slreg_store #(
  parameter int unsigned NUM_WORDS  = 16,
  parameter int unsigned NUM_SLICES = 4,
  parameter int unsigned SLICE_W    = 8,
  localparam int unsigned WORD_W    = NUM_SLICES * SLICE_W
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_WORDS-1:1][NUM_SLICES-1:0] slice_we_i,
  input  logic [SLICE_W-1:0]                   wr_data_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]     words_o
);
  // Word 0 has no flops: constant zero from power-on.
  assign words_o[0] = '0;

  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      logic [SLICE_W-1:0] lane_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)               lane_q <= '0;
        else if (slice_we_i[w][s]) lane_q <= wr_data_i;
      end
      assign words_o[w][s*SLICE_W +: SLICE_W] = lane_q;
    end
  end

  AST_RST_CLEARS: assert property (@(posedge clk_i)
    !rst_ni |=> (words_o == '0)); // R4
endmodule

// File: rtl/slreg_rd_port.sv
module slreg_rd_port #(
  parameter int unsigned NUM_WORDS  = 16,
  parameter int unsigned NUM_SLICES = 4,
  parameter int unsigned SLICE_W    = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned SEL_W      = 2,
  localparam int unsigned WORD_W    = NUM_SLICES * SLICE_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
  input  logic [ADDR_W-1:0]                rd_addr_i,
  input  logic [SEL_W-1:0]                 slice_sel_i,
  output logic [SLICE_W-1:0]               rd_data_o
);
  logic [WORD_W-1:0] word_sel;

  always_comb begin
    word_sel  = words_i[rd_addr_i];
    rd_data_o = word_sel[slice_sel_i*SLICE_W +: SLICE_W];
    if (rd_addr_i == '0) rd_data_o = '0;
  end

  AST_ZERO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == '0) |-> (rd_data_o == '0)); // R8
endmodule

// File: rtl/slreg_file.sv
module slreg_file
  import slreg_pkg::*;
#(
  parameter int unsigned WORD_W  = SLREG_WORD_W,
  parameter int unsigned SLICE_W = SLREG_SLICE_W,
  parameter int unsigned ADDR_W  = SLREG_ADDR_W,
  parameter int unsigned NUM_RD  = SLREG_NUM_RD,
  localparam int unsigned NUM_WORDS  = 1 << ADDR_W,
  localparam int unsigned NUM_SLICES = WORD_W / SLICE_W,
  localparam int unsigned SEL_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SEL_W-1:0]                 slice_sel_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]    rd_addr_i,
  output logic [NUM_RD-1:0][SLICE_W-1:0]   rd_data_o,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [SLICE_W-1:0]               wr_data_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] dbg_words_o
);
  logic [NUM_WORDS-1:1][NUM_SLICES-1:0] slice_we;
  logic [NUM_WORDS-1:0][WORD_W-1:0]     words;

  slreg_wdec #(
    .NUM_WORDS(NUM_WORDS), .NUM_SLICES(NUM_SLICES),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_wdec (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .slice_sel_i(slice_sel_i),
    .slice_we_o (slice_we)
  );

  slreg_store #(
    .NUM_WORDS(NUM_WORDS), .NUM_SLICES(NUM_SLICES), .SLICE_W(SLICE_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slice_we_i(slice_we),
    .wr_data_i (wr_data_i),
    .words_o   (words)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    slreg_rd_port #(
      .NUM_WORDS(NUM_WORDS), .NUM_SLICES(NUM_SLICES), .SLICE_W(SLICE_W),
      .ADDR_W(ADDR_W), .SEL_W(SEL_W)
    ) u_rd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .words_i    (words),
      .rd_addr_i  (rd_addr_i[p]),
      .slice_sel_i(slice_sel_i),
      .rd_data_o  (rd_data_o[p])
    );
  end

  assign dbg_words_o = words;

  // Capture of the last accepted write, used only by the check below.
  logic               chk_wr_q;
  logic [ADDR_W-1:0]  chk_addr_q;
  logic [SEL_W-1:0]   chk_sel_q;
  logic [SLICE_W-1:0] chk_data_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      chk_wr_q   <= 1'b0;
      chk_addr_q <= '0;
      chk_sel_q  <= '0;
      chk_data_q <= '0;
    end else begin
      chk_wr_q   <= wr_en_i && (wr_addr_i != '0);
      chk_addr_q <= wr_addr_i;
      chk_sel_q  <= slice_sel_i;
      chk_data_q <= wr_data_i;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_wr_q |-> (dbg_words_o[chk_addr_q][chk_sel_q*SLICE_W +: SLICE_W] == chk_data_q)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(dbg_words_o)); // R5
  AST_WORD0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0) |=> (dbg_words_o[0] == '0)); // R7
endmodule

// File: tb/tb_slreg_file.sv
`timescale 1ns/1ps
module tb_slreg_file;
  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [1:0]       slice_sel_i;
  logic [1:0][3:0]  rd_addr_i;
  logic [1:0][7:0]  rd_data_o;
  logic             wr_en_i;
  logic [3:0]       wr_addr_i;
  logic [7:0]       wr_data_i;
  logic [15:0][31:0] dbg_words_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  slreg_file dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slice_sel_i(slice_sel_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .dbg_words_o(dbg_words_o)
  );

  // {wen, waddr, sel, wdata, raddr0, raddr1, exp0, exp1}; reads sampled before the edge
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 4'd5,  2'd0, 8'hA1, 4'd5,  4'd0,  8'h00, 8'h00},
    {1'b1, 4'd5,  2'd2, 8'hC3, 4'd5,  4'd5,  8'h00, 8'h00},
    {1'b0, 4'd5,  2'd0, 8'hFF, 4'd5,  4'd5,  8'hA1, 8'hA1},
    {1'b0, 4'd7,  2'd3, 8'hEE, 4'd5,  4'd7,  8'h00, 8'h00},
    {1'b1, 4'd0,  2'd1, 8'h77, 4'd0,  4'd5,  8'h00, 8'h00},
    {1'b1, 4'd15, 2'd3, 8'h9C, 4'd0,  4'd5,  8'h00, 8'h00},
    {1'b1, 4'd15, 2'd1, 8'h5A, 4'd15, 4'd5,  8'h00, 8'h00},
    {1'b0, 4'd1,  2'd3, 8'h11, 4'd15, 4'd5,  8'h9C, 8'h00},
    {1'b0, 4'd1,  2'd2, 8'h22, 4'd5,  4'd15, 8'hC3, 8'h00},
    {1'b0, 4'd1,  2'd1, 8'h33, 4'd15, 4'd0,  8'h5A, 8'h00},
    {1'b1, 4'd5,  2'd0, 8'hB4, 4'd5,  4'd15, 8'hA1, 8'h00},
    {1'b0, 4'd5,  2'd0, 8'h00, 4'd5,  4'd5,  8'hB4, 8'hB4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    slice_sel_i = 2'd0; rd_addr_i = '0;
    #1;
    check("R8 power-on read0", {24'h0, rd_data_o[0]}, 32'h0);
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    check("R4 reset state", {31'h0, dbg_words_o == '0}, 32'h1);
    rst_ni = 1'b1;

    // R1/R3/R5/R6/R7/R9 via vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_en_i      = VEC[i][38];
      wr_addr_i    = VEC[i][37:34];
      slice_sel_i  = VEC[i][33:32];
      wr_data_i    = VEC[i][31:24];
      rd_addr_i[0] = VEC[i][23:20];
      rd_addr_i[1] = VEC[i][19:16];
      #2;
      check("R1/R3/R9 port0", {24'h0, rd_data_o[0]}, {24'h0, VEC[i][15:8]});
      check("R1/R3/R9 port1", {24'h0, rd_data_o[1]}, {24'h0, VEC[i][7:0]});
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R6 R10 word5", dbg_words_o[5], 32'h00C300B4);
    check("R6 R10 word15", dbg_words_o[15], 32'h9C005A00);
    check("R5 word7 untouched", dbg_words_o[7], 32'h0);
    check("R5 word1 untouched", dbg_words_o[1], 32'h0);
    check("R7 word0", dbg_words_o[0], 32'h0);

    // R2: read follows address and select with no clock edge in between
    rd_addr_i[0] = 4'd15; slice_sel_i = 2'd3; #1;
    check("R2 comb read", {24'h0, rd_data_o[0]}, 32'h9C);
    slice_sel_i = 2'd1; #1;
    check("R2 comb select", {24'h0, rd_data_o[0]}, 32'h5A);

    // R7/R8: write to word 0 then read it
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 8'hDD; slice_sel_i = 2'd2;
    rd_addr_i[0] = 4'd0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R8 read0 after write", {24'h0, rd_data_o[0]}, 32'h0);
    check("R7 word0 after write", dbg_words_o[0], 32'h0);

    // R4: reset with a concurrent write
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b1; wr_addr_i = 4'd9; wr_data_i = 8'h55;
    @(negedge clk_i);
    rst_ni = 1'b1; wr_en_i = 1'b0;
    check("R4 reset clears", {31'h0, dbg_words_o == '0}, 32'h1);
    rd_addr_i[1] = 4'd15; slice_sel_i = 2'd3; #1;
    check("R4 read after reset", {24'h0, rd_data_o[1]}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule